// File: doc/BRIEF.md
# Binary-Weighted Periodic Rate Generator

This block turns a one-cycle enable strobe, asserted at a 32768 Hz rate in the system clock domain, into a programmable periodic tick. A 4-bit rate code selects a period that is a power of two of strobes. Each tick produces a one-cycle periodic-event pulse for the interrupt flag logic and, separately, a one-cycle square-wave style pulse for an external pin.

The strobes advance a free-running counter that never stops or restarts, whatever the code or the enables are. A tick falls on a strobe that takes the counter to a multiple of the current period. So after the code or the enables change, the next tick lands on the next aligned boundary, not one full period after the change. The code and the enables are read combinationally on every strobe. A new register value therefore takes effect at the very next strobe.

Top module: `periodic_rate_gen`

## Requirements
- R1: After reset both outputs are low and the free-running count is zero. The first strobe takes the count to 1, so with rate code 3 the first pulse follows the 4th strobe.
- R2: With rate code 0 neither output pulses, even when both enables are set.
- R3: With both the periodic enable and the square-wave enable low, neither output pulses, whatever the rate code is.
- R4: For rate codes 3 to 15 the period is 2^(code-1) strobes. Code 3 gives 4 strobes and code 15 gives 16384.
- R5: Rate codes 1 and 2 act as codes 8 and 9, giving periods of 128 and 256 strobes.
- R6: A pulse follows a strobe only when that strobe takes the free-running count to a multiple of the current period. A change of code in mid-count therefore aligns the next pulse to that boundary.
- R7: `periodic_o` pulses only while `periodic_en_i` is high, and `sqw_o` pulses only while `sqw_en_i` is high. Each pulse lasts exactly one clock.
- R8: A pulse appears in the clock cycle right after the strobe cycle, and never after a cycle without a strobe.
- R9: The free-running count is 15 bits wide and wraps from 32767 to 0. The strobe that wraps it is a boundary for every period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle strobe at the 32768 Hz rate |
| rate_code_i | input | 4 | Rate select code (0 stops the generator) |
| periodic_en_i | input | 1 | Periodic interrupt enable |
| sqw_en_i | input | 1 | Square-wave pulse enable |
| periodic_o | output | 1 | One-cycle periodic-event pulse |
| sqw_o | output | 1 | One-cycle square-wave pulse |

## Verification
The bench steps through every rate code with strobes on every clock. Each code runs for two full periods, and the strobe count in the bench is carried over from one code to the next. This separates a correct period from an off-by-one shift, and a phase-aligned tick from one counted from the moment of the write. Runs where strobes alternate with empty cycles tell a registered pulse from a combinational one and from a pulse made without a strobe. Runs with only one enable set, with none set, and with code 0 tell the output gating apart from the run condition. The remapped codes 1 and 2 and the wrap of the 15-bit count are part of the same sweep.

// File: rtl/rate_gen_pkg.sv
package rate_gen_pkg;
  typedef logic [3:0] rate_code_t;

  // codes 1 and 2 fall back to the slow rates 8 and 9
  function automatic rate_code_t eff_code(input rate_code_t c);
    if (c == 4'd1 || c == 4'd2) return c + 4'd7;
    return c;
  endfunction
endpackage

// File: rtl/rate_decode.sv
module rate_decode
  import rate_gen_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  rate_code_t        code_i,
  input  logic              periodic_en_i,
  input  logic              sqw_en_i,
  output logic              run_o,
  output logic [CNT_W-1:0]  mask_o
);
  rate_code_t eff;
  logic [3:0] shift;

  assign eff   = eff_code(code_i);
  assign shift = (eff == 4'd0) ? 4'd0 : eff - 4'd1;
  assign run_o = (code_i != 4'd0) && (periodic_en_i || sqw_en_i);

  // low (code-1) bits of the count must be zero on a tick
  for (genvar g = 0; g < CNT_W; g++) begin : g_mask
    assign mask_o[g] = (g < int'(shift));
  end
endmodule

// File: rtl/phase_counter.sv
module phase_counter #(
  parameter int CNT_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  output logic [CNT_W-1:0] next_o
);
  logic [CNT_W-1:0] cnt_q;

  assign next_o = cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (step_i) cnt_q <= next_o;
  end
endmodule

// File: rtl/periodic_rate_gen.sv
module periodic_rate_gen #(
  parameter int CNT_W = 15
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [3:0] rate_code_i,
  input  logic       periodic_en_i,
  input  logic       sqw_en_i,
  output logic       periodic_o,
  output logic       sqw_o
);
  logic             run;
  logic [CNT_W-1:0] mask;
  logic [CNT_W-1:0] cnt_next;
  logic             fire;
  logic             periodic_q, sqw_q;

  rate_decode #(.CNT_W(CNT_W)) i_rate_decode (
    .code_i        (rate_code_i),
    .periodic_en_i (periodic_en_i),
    .sqw_en_i      (sqw_en_i),
    .run_o         (run),
    .mask_o        (mask)
  );

  phase_counter #(.CNT_W(CNT_W)) i_phase_counter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (tick_i),
    .next_o (cnt_next)
  );

  assign fire = tick_i && run && ((cnt_next & mask) == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      periodic_q <= 1'b0;
      sqw_q      <= 1'b0;
    end else begin
      periodic_q <= fire && periodic_en_i;
      sqw_q      <= fire && sqw_en_i;
    end
  end

  assign periodic_o = periodic_q;
  assign sqw_o      = sqw_q;
endmodule

// File: rtl/periodic_rate_gen_chk.sv
module periodic_rate_gen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic [3:0] rate_code_i,
  input logic       periodic_en_i,
  input logic       sqw_en_i,
  input logic       periodic_o,
  input logic       sqw_o
);
  p_code_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_code_i == 4'd0) |=> (!periodic_o && !sqw_o));

  p_no_enable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!periodic_en_i && !sqw_en_i) |=> (!periodic_o && !sqw_o));

  p_pie_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !periodic_en_i |=> !periodic_o);

  p_sqw_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sqw_en_i |=> !sqw_o);

  p_single_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (periodic_o || sqw_o) |=> (!periodic_o && !sqw_o));

  p_needs_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> (!periodic_o && !sqw_o));
endmodule

bind periodic_rate_gen periodic_rate_gen_chk i_periodic_rate_gen_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .tick_i        (tick_i),
  .rate_code_i   (rate_code_i),
  .periodic_en_i (periodic_en_i),
  .sqw_en_i      (sqw_en_i),
  .periodic_o    (periodic_o),
  .sqw_o         (sqw_o)
);

// File: tb/test_periodic_rate_gen.sv
module test_periodic_rate_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WRAP = 32768;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [3:0] code = 4'd0;
  logic       pie = 1'b0;
  logic       sqwe = 1'b0;
  logic       periodic_o, sqw_o;

  int n_checks = 0;
  int n_fail = 0;
  int k = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  periodic_rate_gen i_periodic_rate_gen (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .tick_i        (tick),
    .rate_code_i   (code),
    .periodic_en_i (pie),
    .sqw_en_i      (sqwe),
    .periodic_o    (periodic_o),
    .sqw_o         (sqw_o)
  );

  function automatic int period_of(input logic [3:0] c);
    int e;
    e = (c == 4'd1 || c == 4'd2) ? int'(c) + 7 : int'(c);
    return 1 << (e - 1);
  endfunction

  task automatic check(input string req, input string what, input logic got, input logic exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s got %0b exp %0b (code %0d count %0d)", req, what, got, exp, code, k);
    end
  endtask

  // one clock with strobe t; outputs compared at the following negedge
  task automatic step(input logic t, input string req);
    logic fire;
    @(negedge clk);
    tick = t;
    fire = 1'b0;
    if (t) begin
      k = (k + 1) % WRAP;
      fire = (code != 4'd0) && (pie || sqwe) && ((k % period_of(code)) == 0);
    end
    @(negedge clk);
    check(req, "periodic_o", periodic_o, fire && pie);
    check(req, "sqw_o", sqw_o, fire && sqwe);
    tick = 1'b0;
  endtask

  task automatic run(input int n, input string req);
    for (int i = 0; i < n; i++) step(1'b1, req);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "periodic_o in reset", periodic_o, 1'b0);
    check("R1", "sqw_o in reset", sqw_o, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "periodic_o after reset", periodic_o, 1'b0);
    code = 4'd3; pie = 1'b1; sqwe = 1'b1;
    // R1: phase from zero, first pulse after 4th strobe
    run(12, "R1");
    // R8: strobes interleaved with idle cycles
    for (int i = 0; i < 40; i++) step(i[0] == 1'b0, "R8");
    // R4 sweep, count carried across codes; code 15 crosses the wrap (R9)
    for (int c = 4; c <= 15; c++) begin
      code = c[3:0];
      run(2 * period_of(code) + 8, (c == 15) ? "R9" : "R4");
    end
    // R5: remapped codes
    code = 4'd1; run(2 * period_of(4'd1) + 8, "R5");
    code = 4'd2; run(2 * period_of(4'd2) + 8, "R5");
    // R6: switch codes mid-period
    code = 4'd6; run(37, "R6");
    code = 4'd3; run(21, "R6");
    code = 4'd5; run(70, "R6");
    // R7: single enables
    code = 4'd3;
    pie = 1'b1; sqwe = 1'b0; run(40, "R7");
    pie = 1'b0; sqwe = 1'b1; run(40, "R7");
    // R3: no enables
    pie = 1'b0; sqwe = 1'b0; run(40, "R3");
    // R2: code 0 with both enables
    pie = 1'b1; sqwe = 1'b1; code = 4'd0; run(40, "R2");
    // back on, phase still aligned to the free-running count
    code = 4'd4; run(40, "R6");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule